// File: doc/BRIEF.md
# Outstanding Miss Tracking Table

This block keeps track of cache misses that have been sent to the next memory level and have not yet been answered. It is fully associative. Each slot holds one block address and a short list of the small request IDs that are waiting on that block. A later miss to a block that is already outstanding is merged onto the existing slot, up to a fixed per-slot limit. It does not open a second slot.

The cache controller presents a lookup address. In the same cycle the table reports whether that block is already pending, and whether a new request for it can be accepted. The answer to the second question depends on the address. With one strobe the controller then adds the request, either as a merge or as a new allocation. When the lower level returns a block, the fill strobe marks the matching slot as answered. The table reports whether any of the merged requests was atomic, or raises an error if no slot was waiting for that address.

Answered slots are queued in the order their fills arrived. A drain port hands their waiting request IDs back one per cycle, each with its block address. A slot is released for reuse when its last ID has been taken.

Top module: `miss_track_table`

## Requirements
- R1: After synchronous reset every slot is free: `rdy`, `lkp_pending` and `lkp_full` are 0 for any address.
- R2: `lkp_pending` is 1 exactly when a slot holds `lkp_addr` and that slot has not yet been filled.
- R3: For a pending address, `lkp_full` is 1 exactly when that slot already holds `MAX_MERGE` requests. A slot holding fewer requests reports 0.
- R4: For an address that is not pending, `lkp_full` is 1 exactly when all `N_ENTRIES` slots are occupied. Occupied slots include slots that are filled but not yet drained.
- R5: An `add_valid` strobe while `lkp_full` is 1 is ignored. No slot is allocated, nothing is merged, and the dropped ID is never returned by the drain port.
- R6: An accepted add of a pending address merges onto that slot. An accepted add of any other address allocates a free slot, which then reports pending.
- R7: During a `fill_valid` cycle that matches a pending slot, `fill_atomic` is the OR of the `add_atomic` bits of all requests merged onto that slot.
- R8: A fill whose address matches no pending slot raises `fill_err` in that cycle and changes nothing. This includes a slot that has already been filled.
- R9: `rdy` is 1 while any filled slot still holds undelivered IDs. `out_id` and `out_addr` show the next one and stay unchanged until `pop` is asserted with `rdy`.
- R10: The IDs of one slot are delivered in the order their requests were added.
- R11: Only one slot drains at a time. Filled slots are drained completely, one after another, in the order of their fills.
- R12: A slot becomes free in the cycle after its last ID is popped. A table that was full then accepts a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_addr | input | ADDR_W | Block address for the lookup and the add |
| lkp_pending | output | 1 | Block at `lkp_addr` is outstanding and unfilled |
| lkp_full | output | 1 | A request for `lkp_addr` cannot be accepted now |
| add_valid | input | 1 | Add a request for `lkp_addr` |
| add_id | input | ID_W | Request ID being added |
| add_atomic | input | 1 | Request being added is atomic |
| fill_valid | input | 1 | A block returned from the lower level |
| fill_addr | input | ADDR_W | Address of the returned block |
| fill_atomic | output | 1 | Matched slot holds at least one atomic request |
| fill_err | output | 1 | Fill matched no pending slot |
| rdy | output | 1 | A returned ID is available on the drain port |
| pop | input | 1 | Take the ID shown on the drain port |
| out_id | output | ID_W | Next returned request ID |
| out_addr | output | ADDR_W | Block address of `out_id` |

## Verification
The hardest case to reach is the per-address meaning of `lkp_full` while other slots are in mid-drain. A slot must be filled to the merge limit, and the table must be filled with distinct addresses. Both must be probed while some slots are answered but not yet emptied. The stimulus first holds the drain port idle so that answered slots pile up in the ready queue. It offers an extra request to a slot at its limit and to an all-occupied table. It then opens the drain, and the scoreboard shows that the dropped IDs never appear and that fill order is kept. Repeated fills and fills to unknown addresses are placed between these steps.

// File: rtl/mtt_pkg.sv
package mtt_pkg;

    typedef enum logic [1:0] {
        ADD_IDLE,
        ADD_MERGE,
        ADD_ALLOC,
        ADD_DROP
    } add_act_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mtt_match.sv
module mtt_match #(
    parameter int N_ENTRIES = 4,
    parameter int ADDR_W    = 16
) (
    input  logic [N_ENTRIES-1:0]        slot_used,
    input  logic [N_ENTRIES-1:0]        slot_done,
    input  logic [N_ENTRIES*ADDR_W-1:0] slot_addr_flat,
    input  logic [ADDR_W-1:0]           key,
    output logic [N_ENTRIES-1:0]        hit
);
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign hit[g] = slot_used[g] && !slot_done[g] &&
                        (slot_addr_flat[g*ADDR_W +: ADDR_W] == key);
    end
endmodule

// File: rtl/mtt_order_fifo.sv
module mtt_order_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty
);
    localparam int AW = mtt_pkg::idx_w(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign head     = mem[rp];
    assign nonempty = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + (AW+1)'(1);
                2'b01:   cnt <= cnt - (AW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_data;
    end
endmodule

// File: rtl/miss_track_table.sv
module miss_track_table
    import mtt_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    parameter int MAX_MERGE = 4,
    parameter int ADDR_W    = 16,
    parameter int ID_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic              lkp_pending,
    output logic              lkp_full,
    input  logic              add_valid,
    input  logic [ID_W-1:0]   add_id,
    input  logic              add_atomic,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              fill_atomic,
    output logic              fill_err,
    output logic              rdy,
    input  logic              pop,
    output logic [ID_W-1:0]   out_id,
    output logic [ADDR_W-1:0] out_addr
);
    localparam int EW = idx_w(N_ENTRIES);
    localparam int PW = idx_w(MAX_MERGE);
    localparam int CW = $clog2(MAX_MERGE + 1);

    // slot state
    logic [N_ENTRIES-1:0] ent_v;
    logic [N_ENTRIES-1:0] ent_r;
    logic [N_ENTRIES-1:0] ent_at;
    logic [ADDR_W-1:0]    ent_addr [N_ENTRIES];
    logic [CW-1:0]        ent_cnt  [N_ENTRIES];
    logic [ID_W-1:0]      ent_ids  [N_ENTRIES][MAX_MERGE];
    logic [N_ENTRIES*ADDR_W-1:0] addr_flat;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_flat
        assign addr_flat[g*ADDR_W +: ADDR_W] = ent_addr[g];
    end

    // lookups
    logic [N_ENTRIES-1:0] lkp_vec, fill_vec;
    logic [EW-1:0]        lkp_idx, fill_idx, free_idx;
    logic                 fill_hit, free_any;

    mtt_match #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_lkp_cam (
        .slot_used(ent_v), .slot_done(ent_r), .slot_addr_flat(addr_flat),
        .key(lkp_addr), .hit(lkp_vec)
    );

    mtt_match #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_fill_cam (
        .slot_used(ent_v), .slot_done(ent_r), .slot_addr_flat(addr_flat),
        .key(fill_addr), .hit(fill_vec)
    );

    always_comb begin
        lkp_idx  = '0;
        fill_idx = '0;
        free_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (lkp_vec[i])  lkp_idx  = EW'(i);
            if (fill_vec[i]) fill_idx = EW'(i);
            if (!ent_v[i])   free_idx = EW'(i);
        end
    end

    assign lkp_pending = |lkp_vec;
    assign fill_hit    = |fill_vec;
    assign free_any    = ~&ent_v;
    assign lkp_full    = lkp_pending ? (ent_cnt[lkp_idx] == CW'(MAX_MERGE)) : !free_any;
    assign fill_atomic = fill_valid && fill_hit && ent_at[fill_idx];
    assign fill_err    = fill_valid && !fill_hit;

    add_act_e act;
    always_comb begin
        if (!add_valid)      act = ADD_IDLE;
        else if (lkp_full)   act = ADD_DROP;
        else if (lkp_pending) act = ADD_MERGE;
        else                 act = ADD_ALLOC;
    end

    // drain side
    logic [EW-1:0] hd_idx;
    logic [CW-1:0] dpos;
    logic          pop_do, last_one, fill_do;

    assign fill_do  = fill_valid && fill_hit;
    assign pop_do   = pop && rdy;
    assign last_one = ((dpos + CW'(1)) == ent_cnt[hd_idx]);
    assign out_id   = ent_ids[hd_idx][dpos[PW-1:0]];
    assign out_addr = ent_addr[hd_idx];

    mtt_order_fifo #(.DEPTH(N_ENTRIES), .W(EW)) u_order (
        .clk(clk), .rst(rst),
        .push(fill_do), .push_data(fill_idx),
        .pop(pop_do && last_one),
        .head(hd_idx), .nonempty(rdy)
    );

    // control state
    always_ff @(posedge clk) begin
        if (rst) begin
            ent_v  <= '0;
            ent_r  <= '0;
            ent_at <= '0;
            dpos   <= '0;
        end else begin
            case (act)
                ADD_MERGE: begin
                    ent_cnt[lkp_idx] <= ent_cnt[lkp_idx] + CW'(1);
                    ent_at[lkp_idx]  <= ent_at[lkp_idx] | add_atomic;
                end
                ADD_ALLOC: begin
                    ent_v[free_idx]   <= 1'b1;
                    ent_r[free_idx]   <= 1'b0;
                    ent_cnt[free_idx] <= CW'(1);
                    ent_at[free_idx]  <= add_atomic;
                end
                default: ;
            endcase
            if (fill_do) ent_r[fill_idx] <= 1'b1;
            if (pop_do) begin
                if (last_one) begin
                    ent_v[hd_idx] <= 1'b0;
                    ent_r[hd_idx] <= 1'b0;
                    dpos          <= '0;
                end else begin
                    dpos <= dpos + CW'(1);
                end
            end
        end
    end

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (act == ADD_MERGE)
            ent_ids[lkp_idx][ent_cnt[lkp_idx][PW-1:0]] <= add_id;
        if (act == ADD_ALLOC) begin
            ent_ids[free_idx][0] <= add_id;
            ent_addr[free_idx]   <= lkp_addr;
        end
    end
endmodule

// File: rtl/mtt_checker.sv
module mtt_checker #(
    parameter int N_ENTRIES = 4,
    parameter int ID_W      = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 lkp_pending,
    input logic                 lkp_full,
    input logic                 add_valid,
    input logic                 rdy,
    input logic                 pop,
    input logic [ID_W-1:0]      out_id,
    input logic [N_ENTRIES-1:0] ent_v
);
    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rdy && !lkp_pending));

    // R4
    a_r4_full_when_occupied: assert property (@(posedge clk) disable iff (rst)
        (!lkp_pending && ($countones(ent_v) == N_ENTRIES)) |-> lkp_full);

    // R5
    a_r5_drop_no_alloc: assert property (@(posedge clk) disable iff (rst)
        (add_valid && lkp_full && !lkp_pending)
        |=> ($countones(ent_v) <= $past($countones(ent_v))));

    // R9
    a_r9_head_held: assert property (@(posedge clk) disable iff (rst)
        (rdy && !pop) |=> (rdy && $stable(out_id)));
endmodule

bind miss_track_table mtt_checker #(.N_ENTRIES(N_ENTRIES), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst(rst), .lkp_pending(lkp_pending), .lkp_full(lkp_full),
    .add_valid(add_valid), .rdy(rdy), .pop(pop), .out_id(out_id), .ent_v(ent_v)
);

// File: tb/sim_miss_track_table.sv
`timescale 1ns/1ps
module sim_miss_track_table;
    localparam int N  = 4;
    localparam int MM = 4;
    localparam int AW = 16;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] lkp_addr = '0;
    logic add_valid = 1'b0, add_atomic = 1'b0;
    logic [IW-1:0] add_id = '0;
    logic fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic pop = 1'b0;
    logic lkp_pending, lkp_full, fill_atomic, fill_err, rdy;
    logic [IW-1:0] out_id;
    logic [AW-1:0] out_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit drain_en = 1'b0;
    logic [AW+IW-1:0] exp_q [$];

    always #2 clk = ~clk;

    miss_track_table #(.N_ENTRIES(N), .MAX_MERGE(MM), .ADDR_W(AW), .ID_W(IW)) u0 (
        .clk(clk), .rst(rst), .lkp_addr(lkp_addr), .lkp_pending(lkp_pending),
        .lkp_full(lkp_full), .add_valid(add_valid), .add_id(add_id),
        .add_atomic(add_atomic), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_atomic(fill_atomic), .fill_err(fill_err), .rdy(rdy), .pop(pop),
        .out_id(out_id), .out_addr(out_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // probe: set lookup address, compare pending/full
    task automatic probe(input logic [AW-1:0] a, input bit e_pend, input bit e_full,
                         input string req);
        @(negedge clk);
        lkp_addr = a;
        #1;
        chk(lkp_pending == e_pend, req, "lkp_pending", int'(lkp_pending), int'(e_pend));
        chk(lkp_full == e_full, req, "lkp_full", int'(lkp_full), int'(e_full));
    endtask

    task automatic do_add(input logic [AW-1:0] a, input logic [IW-1:0] id, input bit at);
        @(negedge clk);
        lkp_addr = a; add_id = id; add_atomic = at; add_valid = 1'b1;
        @(negedge clk);
        add_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [AW-1:0] a, input bit e_at, input bit e_err,
                           input string req);
        @(negedge clk);
        fill_addr = a; fill_valid = 1'b1;
        #1;
        chk(fill_err == e_err, req, "fill_err", int'(fill_err), int'(e_err));
        chk(fill_atomic == e_at, req, "fill_atomic", int'(fill_atomic), int'(e_at));
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic expect_item(input logic [AW-1:0] a, input logic [IW-1:0] id);
        exp_q.push_back({a, id});
    endtask

    task automatic drain_all(input string req);
        drain_en = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        drain_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(rdy == 1'b0, req, "rdy after drain", int'(rdy), 0);
    endtask

    // monitor: compares drain port against scoreboard queue (R10, R11)
    initial begin
        forever begin
            @(negedge clk);
            pop = 1'b0;
            #1;
            if (drain_en && rdy) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected id", int'(out_id), -1);
                end else begin
                    logic [AW+IW-1:0] e;
                    e = exp_q.pop_front();
                    chk({out_addr, out_id} == e, "R10/R11", "drain item",
                        int'({out_addr, out_id}), int'(e));
                end
                pop = 1'b1;
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        probe(16'h0040, 1'b0, 1'b0, "R1");
        chk(rdy == 1'b0, "R1", "rdy", int'(rdy), 0);

        // R6 allocate and merge up to the limit
        do_add(16'h0040, 4'd1, 1'b0);
        probe(16'h0040, 1'b1, 1'b0, "R2");
        do_add(16'h0040, 4'd2, 1'b0);
        do_add(16'h0040, 4'd3, 1'b1);
        probe(16'h0040, 1'b1, 1'b0, "R3");
        do_add(16'h0040, 4'd4, 1'b0);
        probe(16'h0040, 1'b1, 1'b1, "R3");
        do_add(16'h0040, 4'd5, 1'b1);            // dropped, R5
        probe(16'h0080, 1'b0, 1'b0, "R4");

        // R7 fill with an atomic member
        do_fill(16'h0040, 1'b1, 1'b0, "R7");
        expect_item(16'h0040, 4'd1); expect_item(16'h0040, 4'd2);
        expect_item(16'h0040, 4'd3); expect_item(16'h0040, 4'd4);
        probe(16'h0040, 1'b0, 1'b0, "R2");
        #1;
        chk(rdy == 1'b1, "R9", "rdy after fill", int'(rdy), 1);
        chk(out_id == 4'd1, "R10", "head id", int'(out_id), 1);
        // second fill of a filled slot is an error (R8)
        do_fill(16'h0040, 1'b0, 1'b1, "R8");

        // second slot filled while first waits (R11)
        do_add(16'h0080, 4'd6, 1'b0);
        probe(16'h0080, 1'b1, 1'b0, "R6");
        do_fill(16'h0080, 1'b0, 1'b0, "R7");
        expect_item(16'h0080, 4'd6);
        drain_all("R9");

        // R8 fill with no slot
        do_fill(16'h0C00, 1'b0, 1'b1, "R8");
        #1;
        chk(rdy == 1'b0, "R8", "rdy after stray fill", int'(rdy), 0);

        // R4 fill the table with distinct blocks
        for (int k = 0; k < N; k++) do_add(16'h0100 + 16'(k), 4'(7 + k), 1'b0);
        probe(16'h0200, 1'b0, 1'b1, "R4");
        do_add(16'h0200, 4'd11, 1'b0);           // dropped, R5
        probe(16'h0200, 1'b0, 1'b1, "R5");
        probe(16'h0101, 1'b1, 1'b0, "R3");

        // filled but undrained slot still occupies (R4)
        do_fill(16'h0100, 1'b0, 1'b0, "R7");
        expect_item(16'h0100, 4'd7);
        probe(16'h0200, 1'b0, 1'b1, "R4");
        drain_all("R9");
        probe(16'h0200, 1'b0, 1'b0, "R12");
        do_add(16'h0200, 4'd12, 1'b1);
        probe(16'h0200, 1'b1, 1'b0, "R6");

        // fills in non-index order: drain follows fill order (R11)
        do_fill(16'h0103, 1'b0, 1'b0, "R7");
        do_fill(16'h0200, 1'b1, 1'b0, "R7");
        do_fill(16'h0101, 1'b0, 1'b0, "R7");
        do_fill(16'h0102, 1'b0, 1'b0, "R7");
        expect_item(16'h0103, 4'd10);
        expect_item(16'h0200, 4'd12);
        expect_item(16'h0101, 4'd8);
        expect_item(16'h0102, 4'd9);
        drain_all("R11");
        probe(16'h0300, 1'b0, 1'b0, "R12");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule